// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 16-bit word-address program counter of a small microcontroller core, together with a 3-bit page register and a shadow copy of that register. Each clock the core presents at most one decoded control strobe. The counter then advances by one, jumps or calls inside an 8K-word page, adds to or overwrites its low byte, takes an interrupt vector, or returns from an interrupt. A jump or call never uses the upper counter bits directly. Its target is the page register concatenated with a 13-bit offset. The page instruction that loads the page register is meant to come just before the jump that needs it.

The counter is split into a low byte and a high byte. Software can overwrite the low byte, which transfers control at once and keeps the current high byte. Software can also add to the low byte, and a carry out of that addition bumps the high byte. The high byte cannot be written. A write aimed at it only lets the counter step on. An interrupt loads the whole vector into the counter, moves the old page bits into the shadow and sets the page bits from the top three vector bits. A return from interrupt takes the counter value from the call stack and the page bits from the shadow. Calls and interrupts offer a return address to the external stack through a push strobe.

Top module: `pgpc_unit`

## Requirements
- R1: While reset is asserted and directly after it, the counter reads 0x0000, the page bits read 0 and the push strobe is low.
- R2: A sequential strobe (step, page load or high-byte write), when it wins, sets the counter to its old value plus one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: A page load copies its 3-bit value into the page bits and advances the counter by one. The new page bits do not change the counter until a jump or call uses them.
- R4: A jump sets the counter to {page[2:0], offset[12:0]}, with the page bits as the 3 most significant bits.
- R5: A call sets the counter to the same target as a jump. In the cycle of the call it raises the push strobe with push data equal to the old counter plus one, modulo 2^16.
- R6: A low-byte write sets counter bits 7:0 to the write data and leaves bits 15:8 unchanged.
- R7: A low-byte add sets bits 7:0 to the 8-bit sum of the old low byte, the write data and, for the add-with-carry variant only, the carry input. If that sum exceeds 0xFF, bits 15:8 are incremented modulo 256. Otherwise they are unchanged.
- R8: A high-byte write has no effect on the counter beyond the one-step advance of R2, and it leaves the page bits unchanged.
- R9: An interrupt sets the counter to the 16-bit vector, sets the page bits to vector bits 15:13 and saves the old page bits in the shadow. In that cycle it raises the push strobe with push data equal to the current counter.
- R10: A return from interrupt sets the counter to the return-address input and the page bits to the shadow value.
- R11: When several strobes arrive together, only the highest one takes effect, in this order: interrupt, return, call, jump, low-byte write, low-byte add, sequential. With no strobe the counter holds.
- R12: The page bits change only on a page load, an interrupt or a return from interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Ordinary instruction: advance by one |
| page_ld_i | input | 1 | Page instruction: load page bits and advance |
| page_val_i | input | 3 | Value for the page bits |
| hi_wr_i | input | 1 | Instruction writing the read-only high byte |
| jump_i | input | 1 | Jump within the selected page |
| call_i | input | 1 | Call within the selected page |
| target_i | input | 13 | In-page offset for a jump or call |
| lo_wr_i | input | 1 | Overwrite the low byte |
| lo_add_i | input | 1 | Add the write data to the low byte |
| lo_addc_i | input | 1 | Also add the carry input in a low-byte add |
| carry_i | input | 1 | Carry flag from the core |
| wdata_i | input | 8 | Write or addend data |
| irq_i | input | 1 | Take an interrupt |
| vector_i | input | 16 | Interrupt vector word address |
| reti_i | input | 1 | Return from interrupt |
| ret_addr_i | input | 16 | Return address popped from the stack |
| pc_o | output | 16 | Program counter |
| page_o | output | 3 | Page bits |
| push_o | output | 1 | Push a return address this cycle |
| push_data_o | output | 16 | Address to push |

## Verification
The assertions assume that every strobe and data input has a known 0 or 1 level from the first clock after reset. They key off the operation the arbiter selects, not the raw strobes. Because of that, they stay valid when several strobes overlap and need no assumption that the strobes are exclusive. Most of the stimulus raises one strobe at a time. A few cycles deliberately raise overlapping strobes to exercise the ordering. Every return from interrupt in the stimulus follows an interrupt, so the shadow holds a meaningful value when it is restored.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
  localparam int PC_W   = 16;
  localparam int PAGE_W = 3;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = PC_W - PAGE_W;
  localparam int HI_W   = PC_W - BYTE_W;

  typedef enum logic [2:0] {
    OP_HOLD, OP_SEQ, OP_ADD, OP_LOW, OP_JMP, OP_CALL, OP_RETI, OP_IRQ
  } pc_op_e;

  // next address in straight-line flow, wraps naturally
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  // page bits on top of the in-page offset
  function automatic logic [PC_W-1:0] page_target(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFF_W-1:0] off);
    return {pg, off};
  endfunction

  // low byte sum with carry out in the top bit
  function automatic logic [BYTE_W:0] lo_sum(input logic [BYTE_W-1:0] lo,
                                             input logic [BYTE_W-1:0] addend,
                                             input logic cin);
    return {1'b0, lo} + {1'b0, addend} + (BYTE_W+1)'(cin);
  endfunction
endpackage

// File: rtl/pgpc_arb.sv
module pgpc_arb
  import pgpc_pkg::*;
(
  input  logic   irq,
  input  logic   reti,
  input  logic   call,
  input  logic   jump,
  input  logic   lo_wr,
  input  logic   lo_add,
  input  logic   seq,
  output pc_op_e op
);
  always_comb begin
    if (irq)         op = OP_IRQ;
    else if (reti)   op = OP_RETI;
    else if (call)   op = OP_CALL;
    else if (jump)   op = OP_JMP;
    else if (lo_wr)  op = OP_LOW;
    else if (lo_add) op = OP_ADD;
    else if (seq)    op = OP_SEQ;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/pgpc_page.sv
module pgpc_page
  import pgpc_pkg::*;
#(
  parameter int PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pc_op_e        op,
  input  logic          page_ld,
  input  logic [PW-1:0] page_val,
  input  logic [PW-1:0] vec_top,
  output logic [PW-1:0] page,
  output logic [PW-1:0] shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page   <= '0;
      shadow <= '0;
    end else begin
      case (op)
        OP_IRQ: begin
          shadow <= page;
          page   <= vec_top;
        end
        OP_RETI: page <= shadow;
        OP_SEQ:  if (page_ld) page <= page_val;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgpc_pcreg.sv
module pgpc_pcreg
  import pgpc_pkg::*;
#(
  parameter int W  = PC_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_op_e            op,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  target,
  input  logic [BW-1:0]     wdata,
  input  logic              add_cin,
  input  logic [W-1:0]      vec,
  input  logic [W-1:0]      ret_addr,
  output logic [W-1:0]      pc,
  output logic              lo_carry
);
  localparam int NLANE = W / BW;

  logic [BW:0]  sum;
  logic [W-1:0] pc_nxt;

  assign sum      = lo_sum(pc[BW-1:0], wdata, add_cin);
  assign lo_carry = (op == OP_ADD) && sum[BW];

  always_comb begin
    case (op)
      OP_SEQ:          pc_nxt = seq_next(pc);
      OP_JMP, OP_CALL: pc_nxt = page_target(page, target);
      OP_LOW:          pc_nxt = {pc[W-1:BW], wdata};
      OP_ADD:          pc_nxt = {pc[W-1:BW] + (W-BW)'(lo_carry), sum[BW-1:0]};
      OP_IRQ:          pc_nxt = vec;
      OP_RETI:         pc_nxt = ret_addr;
      default:         pc_nxt = pc;
    endcase
  end

  // one register per byte lane; upper lanes skip low-only updates
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic          we;
    logic [BW-1:0] lane_q;
    if (g == 0) begin : g_low
      assign we = (op != OP_HOLD);
    end else begin : g_high
      assign we = (op != OP_HOLD) && (op != OP_LOW) && !((op == OP_ADD) && !lo_carry);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q <= '0;
      else if (we) lane_q <= pc_nxt[g*BW +: BW];
    end
    assign pc[g*BW +: BW] = lane_q;
  end
endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit
  import pgpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic        page_ld_i,
  input  logic [2:0]  page_val_i,
  input  logic        hi_wr_i,
  input  logic        jump_i,
  input  logic        call_i,
  input  logic [12:0] target_i,
  input  logic        lo_wr_i,
  input  logic        lo_add_i,
  input  logic        lo_addc_i,
  input  logic        carry_i,
  input  logic [7:0]  wdata_i,
  input  logic        irq_i,
  input  logic [15:0] vector_i,
  input  logic        reti_i,
  input  logic [15:0] ret_addr_i,
  output logic [15:0] pc_o,
  output logic [2:0]  page_o,
  output logic        push_o,
  output logic [15:0] push_data_o
);
  pc_op_e             op_w;
  logic               seq_w;
  logic               add_cin_w;
  logic               lo_carry_w;
  logic [PAGE_W-1:0]  shadow_w;

  assign seq_w     = step_i | page_ld_i | hi_wr_i;
  assign add_cin_w = lo_addc_i & carry_i;

  pgpc_arb arb_i (
    .irq(irq_i), .reti(reti_i), .call(call_i), .jump(jump_i),
    .lo_wr(lo_wr_i), .lo_add(lo_add_i), .seq(seq_w), .op(op_w)
  );

  pgpc_page #(.PW(PAGE_W)) page_i (
    .clk(clk), .rst_n(rst_n), .op(op_w), .page_ld(page_ld_i),
    .page_val(page_val_i), .vec_top(vector_i[PC_W-1 -: PAGE_W]),
    .page(page_o), .shadow(shadow_w)
  );

  pgpc_pcreg #(.W(PC_W), .BW(BYTE_W)) pcreg_i (
    .clk(clk), .rst_n(rst_n), .op(op_w), .page(page_o), .target(target_i),
    .wdata(wdata_i), .add_cin(add_cin_w), .vec(vector_i), .ret_addr(ret_addr_i),
    .pc(pc_o), .lo_carry(lo_carry_w)
  );

  assign push_o      = (op_w == OP_CALL) || (op_w == OP_IRQ);
  assign push_data_o = (op_w == OP_CALL) ? seq_next(pc_o) : pc_o;
endmodule

// File: rtl/pgpc_chk.sv
module pgpc_chk
  import pgpc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input pc_op_e      op,
  input logic        page_ld,
  input logic [15:0] pc,
  input logic [2:0]  page,
  input logic [2:0]  shadow,
  input logic        push,
  input logic [15:0] push_data,
  input logic [12:0] target,
  input logic [7:0]  wdata,
  input logic [15:0] vec,
  input logic [15:0] ret_addr,
  input logic        carry
);
  assert_reset_push_R1: assert property (@(posedge clk) !rst_n |-> !push);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SEQ |=> pc == $past(pc) + 16'd1);

  assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JMP || op == OP_CALL) |=> pc == {$past(page), $past(target)});

  assert_call_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CALL |-> push && push_data == pc + 16'd1);

  assert_push_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (op == OP_CALL || op == OP_IRQ));

  assert_low_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOW |=> pc == {$past(pc[15:8]), $past(wdata)});

  assert_add_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ADD |=> pc[15:8] == $past(pc[15:8]) + {7'd0, $past(carry)});

  assert_irq_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_IRQ |=> pc == $past(vec) && page == $past(vec[15:13]) && shadow == $past(page));

  assert_irq_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_IRQ |-> push && push_data == pc);

  assert_reti_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RETI |=> page == $past(shadow) && pc == $past(ret_addr));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(pc));

  assert_page_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_IRQ && op != OP_RETI && !(op == OP_SEQ && page_ld)) |=> $stable(page));
endmodule

bind pgpc_unit pgpc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op(op_w), .page_ld(page_ld_i), .pc(pc_o),
  .page(page_o), .shadow(shadow_w), .push(push_o), .push_data(push_data_o),
  .target(target_i), .wdata(wdata_i), .vec(vector_i), .ret_addr(ret_addr_i),
  .carry(lo_carry_w)
);

// File: tb/pgpc_unit_tb.sv
`timescale 1ns/1ps
module pgpc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i, page_ld_i, hi_wr_i, jump_i, call_i;
  logic        lo_wr_i, lo_add_i, lo_addc_i, carry_i, irq_i, reti_i;
  logic [2:0]  page_val_i;
  logic [12:0] target_i;
  logic [7:0]  wdata_i;
  logic [15:0] vector_i, ret_addr_i;
  logic [15:0] pc_o, push_data_o;
  logic [2:0]  page_o;
  logic        push_o;

  always #4 clk = ~clk;

  pgpc_unit dut_i (.*);

  typedef struct {
    logic [15:0] pc;
    logic [2:0]  pg;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [15:0] m_pc;
  logic [2:0]  m_page, m_shadow;

  task automatic clear_in();
    {step_i, page_ld_i, hi_wr_i, jump_i, call_i} = '0;
    {lo_wr_i, lo_add_i, lo_addc_i, carry_i, irq_i, reti_i} = '0;
    page_val_i = '0; target_i = '0; wdata_i = '0; vector_i = '0; ret_addr_i = '0;
  endtask

  // driver: inputs already set at a falling edge; predict, check push, queue result
  task automatic fire(input string tag);
    logic [15:0] npc;
    logic [2:0]  npg;
    logic        epush;
    logic [15:0] epd;
    logic [8:0]  s;
    #1;
    npc = m_pc; npg = m_page; epush = 1'b0; epd = '0;
    if (irq_i) begin
      epush = 1'b1; epd = m_pc;
      m_shadow = m_page; npg = vector_i[15:13]; npc = vector_i;
    end else if (reti_i) begin
      npc = ret_addr_i; npg = m_shadow;
    end else if (call_i || jump_i) begin
      npc = {m_page, target_i};
      if (call_i) begin epush = 1'b1; epd = m_pc + 16'd1; end
    end else if (lo_wr_i) begin
      npc = {m_pc[15:8], wdata_i};
    end else if (lo_add_i) begin
      s = {1'b0, m_pc[7:0]} + {1'b0, wdata_i} + {8'd0, lo_addc_i & carry_i};
      npc = {m_pc[15:8] + {7'd0, s[8]}, s[7:0]};
    end else if (step_i || page_ld_i || hi_wr_i) begin
      npc = m_pc + 16'd1;
      if (page_ld_i) npg = page_val_i;
    end
    n_chk++;
    if (push_o !== epush || (epush && push_data_o !== epd))
      $display("FAIL %s push: got %0b/%h expected %0b/%h", tag, push_o, push_data_o, epush, epd);
    if (push_o !== epush || (epush && push_data_o !== epd)) n_err++;
    sb_q.push_back('{npc, npg, tag});
    m_pc = npc; m_page = npg;
    @(negedge clk);
    clear_in();
  endtask

  // monitor: compares registered state after each edge
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (pc_o !== e.pc || page_o !== e.pg) begin
        n_err++;
        $display("FAIL %s: pc=%h page=%0d expected pc=%h page=%0d", e.tag, pc_o, page_o, e.pc, e.pg);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_in();
    m_pc = '0; m_page = '0; m_shadow = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (pc_o !== 16'h0 || page_o !== 3'd0 || push_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 in reset: pc=%h page=%0d push=%0b expected 0/0/0", pc_o, page_o, push_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (pc_o !== 16'h0 || page_o !== 3'd0) begin
      n_err++;
      $display("FAIL R1 after reset: pc=%h page=%0d expected 0000/0", pc_o, page_o);
    end

    step_i = 1; fire("R2 step");
    step_i = 1; fire("R2 step");
    fire("R11 idle hold");
    page_ld_i = 1; page_val_i = 3'd5; fire("R3 page load");
    step_i = 1; fire("R3 page not used by step");
    jump_i = 1; target_i = 13'h0123; fire("R4 jump");
    jump_i = 1; target_i = 13'h1ABC; fire("R4 jump same page R12");
    call_i = 1; target_i = 13'h0040; fire("R5 call");
    lo_wr_i = 1; wdata_i = 8'h77; fire("R6 low write");
    lo_add_i = 1; wdata_i = 8'h05; fire("R7 add no carry");
    lo_add_i = 1; wdata_i = 8'h90; fire("R7 add carry out");
    lo_add_i = 1; lo_addc_i = 1; carry_i = 1; wdata_i = 8'h01; fire("R7 addc with carry in");
    lo_add_i = 1; carry_i = 1; wdata_i = 8'h01; fire("R7 plain add ignores carry in");
    hi_wr_i = 1; wdata_i = 8'hEE; fire("R8 high write ignored");
    page_ld_i = 1; page_val_i = 3'd7; fire("R3 page load 7");
    jump_i = 1; target_i = 13'h1FFF; fire("R4 jump to top");
    step_i = 1; fire("R2 wrap to zero");
    page_ld_i = 1; page_val_i = 3'd7; fire("R3 page load");
    jump_i = 1; target_i = 13'h1FFF; fire("R4 jump to top");
    call_i = 1; target_i = 13'h1FF0; fire("R5 call push wraps");
    jump_i = 1; target_i = 13'h1FFF; fire("R4 reach FFFF");
    lo_add_i = 1; wdata_i = 8'h01; fire("R7 high byte wraps");
    irq_i = 1; vector_i = 16'hA010; fire("R9 interrupt");
    step_i = 1; fire("R2 step in handler");
    reti_i = 1; ret_addr_i = 16'h0042; fire("R10 return");
    irq_i = 1; vector_i = 16'h4000; jump_i = 1; lo_wr_i = 1; reti_i = 1; fire("R11 irq wins");
    reti_i = 1; ret_addr_i = 16'h1234; call_i = 1; lo_wr_i = 1; fire("R11 return wins");
    call_i = 1; jump_i = 1; target_i = 13'h0300; step_i = 1; fire("R11 call over jump");
    jump_i = 1; target_i = 13'h0555; lo_wr_i = 1; wdata_i = 8'h11; fire("R11 jump over write");
    lo_wr_i = 1; lo_add_i = 1; wdata_i = 8'hF0; step_i = 1; fire("R11 write over add");
    lo_add_i = 1; wdata_i = 8'h20; page_ld_i = 1; page_val_i = 3'd2; fire("R11 add over page load R12");
    lo_wr_i = 1; wdata_i = 8'h3C; fire("R12 write keeps page");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule